// File: doc/BRIEF.md
# Pipelined Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two 32-bit single-precision floating-point operands. Each operand has a sign bit in bit 31, an 8-bit exponent biased by 127 in bits 30:23, and a 23-bit fraction in bits 22:0 with an implied leading one. The select input picks a+b or a−b. The datapath has six registered stages: operand classification with exponent difference, significand alignment, significand add, normalisation, rounding, and final exception resolution. It accepts one operation in every clock cycle, and each result leaves with a valid strobe that tracks the input strobe.

The arithmetic is a reduced form of the usual binary32 rules. Rounding is always to nearest with ties to even. Subnormal operands count as zero, and a result below the smallest normal magnitude is flushed to a signed zero. Every NaN the block produces is the one quiet pattern 0x7FC00000. Five exception flags come out with each result. The divide-by-zero flag is carried only so that the flag set is complete, and it is never raised.

The block is meant for a datapath that issues additions at up to one per cycle and can absorb a fixed latency. No handshake is needed, because the pipeline never stalls.

Top module: `fp32_addsub`

## Requirements
- R1: An operation presented with inValid high is sampled at a rising clock edge. Its result, flags and outValid=1 are on the outputs after the sixth rising edge, counting the sampling edge. One operation is accepted on every cycle. outValid is high only for cycles that carry a sampled operation.
- R2: While rst is high (synchronous, active high) the outputs go to outValid=0, result=0 and flags=0. An operation that was in flight when reset was applied produces no valid output.
- R3: Finite normal operands give the sum rounded to nearest, ties to even. The flags field is {invalid, divZero, overflow, underflow, inexact}, from bit 4 down to bit 0. inexact (bit 0) is set only when rounding discarded nonzero bits; an exact result has flags 0.
- R4: With subSel=1 the block computes opA − opB by inverting the sign of opB, and the result carries the sign of the larger-magnitude term.
- R5: A sum that is exactly zero is +0 (0x00000000). The one exception is that two negative zero terms, after the subSel sign inversion, give −0 (0x80000000).
- R6: Infinities of opposite effective sign give 0x7FC00000 with invalid (bit 4) set and no other flag.
- R7: Any NaN operand gives 0x7FC00000 with flags 0.
- R8: An infinity combined with a finite value gives the infinity, with its effective sign, and flags 0.
- R9: A result whose magnitude reaches exponent field 255 after rounding, including a rounding carry out of the largest finite value, gives a correctly signed infinity with overflow (bit 2) and inexact (bit 0) set.
- R10: A nonzero result below the smallest normal magnitude gives a signed zero with underflow (bit 1) and inexact (bit 0) set.
- R11: An operand with exponent field 0 is taken as a zero of its sign whatever its fraction. No result has exponent field 0 with a nonzero fraction.
- R12: The divide-by-zero flag (bit 3) is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operation strobe; operands are sampled when high |
| opA | input | 32 | First operand, single-precision |
| opB | input | 32 | Second operand, single-precision |
| subSel | input | 1 | 0 computes opA+opB, 1 computes opA−opB |
| outValid | output | 1 | High for the cycle in which result and flags are valid |
| result | output | 32 | Rounded single-precision result |
| flags | output | 5 | {invalid, divZero, overflow, underflow, inexact} |

## Verification
The bench checks both tie-to-even rounding directions against a value just above the halfway point. A design that always rounds half up gives 0x3F800001 instead of 1.0, and one that only truncates loses the upward cases. It covers a rounding carry that ripples into the exponent, and a carry out of the largest finite value. A stage that does not re-normalise after rounding gives the wrong exponent in the first case and misses the overflow in the second. It covers cancellation down to a single low bit and flush of a result below the normal range. A faulty leading-zero count shows up as a wrong exponent, and a missing flush shows up as a subnormal pattern or an absent underflow flag. Further vectors cover the sign of exact-zero sums, infinity minus infinity against infinity plus a finite value, NaN canonicalisation, and an operation caught in flight by reset. A design with a wrong latency or wrong valid tracking fails the one-per-cycle stream and the single isolated operation.

// File: rtl/fp32_addsub_pkg.sv
package fp32_addsub_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int EXT_W  = SIG_W + 3;
  localparam int SUM_W  = EXT_W + 1;
  localparam int EXPI_W = EXP_W + 2;
  localparam int LZ_W   = $clog2(EXT_W + 1);
  localparam int SHL    = $clog2(EXT_W);
  localparam int NSTAGE = 6;

  localparam logic [EXP_W-1:0]  EXP_MAX = '1;
  localparam logic [WORD_W-1:0] QNAN    = {1'b0, EXP_MAX, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef struct packed {
    logic [NSTAGE-1:0] load;
  } fpStrobe_t;

  typedef struct packed {
    logic invalid;
    logic divZero;
    logic overflow;
    logic underflow;
    logic inexact;
  } fpFlags_t;

  typedef enum logic [1:0] {SP_NONE, SP_NAN, SP_INF} spKind_t;

  typedef struct packed {
    spKind_t kind;
    logic    sign;
    logic    invalid;
  } spInfo_t;

  typedef struct packed {
    logic             sgnBig;
    logic             effSub;
    logic [EXP_W-1:0] expBig;
    logic [SIG_W-1:0] sigBig;
    logic [SIG_W-1:0] sigSmall;
    logic [EXP_W-1:0] shAmt;
    spInfo_t          sp;
  } s1_t;

  typedef struct packed {
    logic             sgnBig;
    logic             effSub;
    logic [EXP_W-1:0] expBig;
    logic [EXT_W-1:0] extBig;
    logic [EXT_W-1:0] extSmall;
    spInfo_t          sp;
  } s2_t;

  typedef struct packed {
    logic             sgn;
    logic [EXP_W-1:0] expBig;
    logic [SUM_W-1:0] sum;
    spInfo_t          sp;
  } s3_t;

  typedef struct packed {
    logic              sgn;
    logic [EXPI_W-1:0] expN;
    logic [EXT_W-1:0]  norm;
    spInfo_t           sp;
  } s4_t;

  typedef struct packed {
    logic              sgn;
    logic              isZero;
    logic [EXPI_W-1:0] expR;
    logic [FRAC_W-1:0] frac;
    logic              inexact;
    spInfo_t           sp;
  } s5_t;
endpackage

// File: rtl/fp32_addsub_lzc.sv
module fp32_addsub_lzc #(
  parameter int W  = 27,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  // Priority chain: the highest set bit is the last one to assign.
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) cnt = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fp32_addsub_ctrl.sv
module fp32_addsub_ctrl
  import fp32_addsub_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      inValid,
  output fpStrobe_t strobe,
  output logic      outValid
);
  logic [NSTAGE-1:0] vPipe;

  always_ff @(posedge clk) begin
    if (rst) vPipe <= '0;
    else     vPipe <= {vPipe[NSTAGE-2:0], inValid};
  end

  assign strobe.load = {vPipe[NSTAGE-2:0], inValid};
  assign outValid    = vPipe[NSTAGE-1];
endmodule

// File: rtl/fp32_addsub_dp.sv
module fp32_addsub_dp
  import fp32_addsub_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  fpStrobe_t         strobe,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic              subSel,
  output logic [WORD_W-1:0] result,
  output fpFlags_t          flags
);
  s1_t s1d, s1q;
  s2_t s2d, s2q;
  s3_t s3d, s3q;
  s4_t s4d, s4q;
  s5_t s5d, s5q;
  logic [WORD_W-1:0] res6;
  fpFlags_t          flg6;

  // ---------------- stage 1: classify, order, exponent difference
  logic              sA, sB, zA, zB, nanA, nanB, infA, infB, aBig;
  logic [EXP_W-1:0]  eA, eB, eAz, eBz, dAB, dBA;
  logic [FRAC_W-1:0] fA, fB;
  logic [SIG_W-1:0]  sigA, sigB;

  assign sA = opA[WORD_W-1];
  assign sB = opB[WORD_W-1] ^ subSel;
  assign eA = opA[WORD_W-2:FRAC_W];
  assign eB = opB[WORD_W-2:FRAC_W];
  assign fA = opA[FRAC_W-1:0];
  assign fB = opB[FRAC_W-1:0];

  always_comb begin
    zA   = (eA == '0);
    zB   = (eB == '0);
    nanA = (eA == EXP_MAX) && (fA != '0);
    nanB = (eB == EXP_MAX) && (fB != '0);
    infA = (eA == EXP_MAX) && (fA == '0);
    infB = (eB == EXP_MAX) && (fB == '0);
    eAz  = zA ? '0 : eA;
    eBz  = zB ? '0 : eB;
    sigA = zA ? '0 : {1'b1, fA};
    sigB = zB ? '0 : {1'b1, fB};
    aBig = {eAz, sigA[FRAC_W-1:0]} >= {eBz, sigB[FRAC_W-1:0]};
    dAB  = eAz - eBz;
    dBA  = eBz - eAz;

    s1d.sgnBig   = aBig ? sA : sB;
    s1d.effSub   = sA ^ sB;
    s1d.expBig   = aBig ? eAz : eBz;
    s1d.sigBig   = aBig ? sigA : sigB;
    s1d.sigSmall = aBig ? sigB : sigA;
    s1d.shAmt    = aBig ? dAB : dBA;

    s1d.sp = '{kind: SP_NONE, sign: 1'b0, invalid: 1'b0};
    if (nanA || nanB) begin
      s1d.sp.kind = SP_NAN;
    end else if (infA && infB && (sA != sB)) begin
      s1d.sp.kind    = SP_NAN;
      s1d.sp.invalid = 1'b1;
    end else if (infA) begin
      s1d.sp.kind = SP_INF;
      s1d.sp.sign = sA;
    end else if (infB) begin
      s1d.sp.kind = SP_INF;
      s1d.sp.sign = sB;
    end
  end

  // ---------------- stage 2: right-shift alignment with sticky collection
  logic [EXT_W-1:0] shv [SHL+1];
  logic [SHL:0]     stk;
  logic             farShift;

  assign shv[0] = {s1q.sigSmall, 3'b000};
  assign stk[0] = 1'b0;

  for (genvar k = 0; k < SHL; k++) begin : g_align
    localparam int STEP = 1 << k;
    localparam logic [EXT_W-1:0] LOST = EXT_W'((1 << STEP) - 1);
    assign shv[k+1] = s1q.shAmt[k] ? (shv[k] >> STEP) : shv[k];
    assign stk[k+1] = stk[k] | (s1q.shAmt[k] & (|(shv[k] & LOST)));
  end

  assign farShift = |s1q.shAmt[EXP_W-1:SHL];

  always_comb begin
    s2d.sgnBig = s1q.sgnBig;
    s2d.effSub = s1q.effSub;
    s2d.expBig = s1q.expBig;
    s2d.extBig = {s1q.sigBig, 3'b000};
    s2d.extSmall = farShift ? {{(EXT_W-1){1'b0}}, |shv[0]}
                            : {shv[SHL][EXT_W-1:1], shv[SHL][0] | stk[SHL]};
    s2d.sp = s1q.sp;
  end

  // ---------------- stage 3: significand add or subtract
  logic [SUM_W-1:0] sumD;

  always_comb begin
    sumD = s2q.effSub ? ({1'b0, s2q.extBig} - {1'b0, s2q.extSmall})
                      : ({1'b0, s2q.extBig} + {1'b0, s2q.extSmall});
    s3d.sum    = sumD;
    s3d.expBig = s2q.expBig;
    s3d.sgn    = (sumD == '0) ? (~s2q.effSub & s2q.sgnBig) : s2q.sgnBig;
    s3d.sp     = s2q.sp;
  end

  // ---------------- stage 4: normalisation
  logic [LZ_W-1:0] lzCnt;

  fp32_addsub_lzc #(.W(EXT_W), .CW(LZ_W)) u_lzc (
    .vec (s3q.sum[EXT_W-1:0]),
    .cnt (lzCnt)
  );

  always_comb begin
    s4d.sgn = s3q.sgn;
    s4d.sp  = s3q.sp;
    if (s3q.sum[SUM_W-1]) begin
      s4d.norm = {s3q.sum[SUM_W-1:2], s3q.sum[1] | s3q.sum[0]};
      s4d.expN = {{(EXPI_W-EXP_W){1'b0}}, s3q.expBig} + EXPI_W'(1);
    end else begin
      s4d.norm = s3q.sum[EXT_W-1:0] << lzCnt;
      s4d.expN = {{(EXPI_W-EXP_W){1'b0}}, s3q.expBig} - EXPI_W'(lzCnt);
    end
  end

  // ---------------- stage 5: round to nearest, ties to even
  logic             lsb, grd, tail, roundUp;
  logic [SIG_W:0]   sigR;

  always_comb begin
    lsb     = s4q.norm[3];
    grd     = s4q.norm[2];
    tail    = |s4q.norm[1:0];
    roundUp = grd & (tail | lsb);
    sigR    = {1'b0, s4q.norm[EXT_W-1:3]} + {{SIG_W{1'b0}}, roundUp};

    s5d.sgn     = s4q.sgn;
    s5d.sp      = s4q.sp;
    s5d.inexact = grd | tail;
    s5d.isZero  = ~sigR[SIG_W] & ~sigR[FRAC_W];
    if (sigR[SIG_W]) begin
      s5d.expR = s4q.expN + EXPI_W'(1);
      s5d.frac = '0;
    end else begin
      s5d.expR = s4q.expN;
      s5d.frac = sigR[FRAC_W-1:0];
    end
  end

  // ---------------- stage 6: exception resolution
  logic expOvf, expUnf;

  always_comb begin
    expOvf = ~s5q.expR[EXPI_W-1] & (s5q.expR >= {{(EXPI_W-EXP_W){1'b0}}, EXP_MAX});
    expUnf = s5q.expR[EXPI_W-1] | (s5q.expR == '0);
    flg6   = '0;
    res6   = {s5q.sgn, {(WORD_W-1){1'b0}}};
    case (s5q.sp.kind)
      SP_NAN: begin
        res6         = QNAN;
        flg6.invalid = s5q.sp.invalid;
      end
      SP_INF: res6 = {s5q.sp.sign, EXP_MAX, {FRAC_W{1'b0}}};
      default: begin
        if (s5q.isZero) begin
          res6 = {s5q.sgn, {(WORD_W-1){1'b0}}};
        end else if (expOvf) begin
          res6          = {s5q.sgn, EXP_MAX, {FRAC_W{1'b0}}};
          flg6.overflow = 1'b1;
          flg6.inexact  = 1'b1;
        end else if (expUnf) begin
          res6           = {s5q.sgn, {(WORD_W-1){1'b0}}};
          flg6.underflow = 1'b1;
          flg6.inexact   = 1'b1;
        end else begin
          res6         = {s5q.sgn, s5q.expR[EXP_W-1:0], s5q.frac};
          flg6.inexact = s5q.inexact;
        end
      end
    endcase
  end

  // ---------------- stage registers
  always_ff @(posedge clk) begin
    if (rst) begin
      s1q    <= '0;
      s2q    <= '0;
      s3q    <= '0;
      s4q    <= '0;
      s5q    <= '0;
      result <= '0;
      flags  <= '0;
    end else begin
      if (strobe.load[0]) s1q <= s1d;
      if (strobe.load[1]) s2q <= s2d;
      if (strobe.load[2]) s3q <= s3d;
      if (strobe.load[3]) s4q <= s4d;
      if (strobe.load[4]) s5q <= s5d;
      if (strobe.load[5]) begin
        result <= res6;
        flags  <= flg6;
      end
    end
  end
endmodule

// File: rtl/fp32_addsub.sv
module fp32_addsub
  import fp32_addsub_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic              subSel,
  output logic              outValid,
  output logic [WORD_W-1:0] result,
  output logic [4:0]        flags
);
  fpStrobe_t strobe;
  fpFlags_t  dpFlags;

  fp32_addsub_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  fp32_addsub_dp u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .opA    (opA),
    .opB    (opB),
    .subSel (subSel),
    .result (result),
    .flags  (dpFlags)
  );

  assign flags = dpFlags;
endmodule

// File: rtl/fp32_addsub_chk.sv
module fp32_addsub_chk (
  input logic        clk,
  input logic        rst,
  input logic        inValid,
  input logic        outValid,
  input logic [31:0] result,
  input logic [4:0]  flags
);
  logic [2:0] sinceRst;

  always_ff @(posedge clk) begin
    if (rst)                  sinceRst <= 3'd0;
    else if (sinceRst != 3'd6) sinceRst <= sinceRst + 3'd1;
  end

  // R1: valid strobe is the input strobe six edges later
  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    (sinceRst == 3'd6) |-> (outValid == $past(inValid, 6)));

  // R2: reset clears the visible outputs
  p_reset_clear_r2: assert property (@(posedge clk)
    rst |=> (!outValid && result == 32'h0 && flags == 5'h0));

  // R6: invalid only ever comes with the canonical NaN
  p_invalid_nan_r6: assert property (@(posedge clk) disable iff (rst)
    (outValid && flags[4]) |-> (result == 32'h7FC00000));

  // R7: any NaN pattern on the output is the canonical one
  p_nan_canon_r7: assert property (@(posedge clk) disable iff (rst)
    (outValid && result[30:23] == 8'hFF && result[22:0] != 23'h0) |-> (result == 32'h7FC00000));

  // R9: overflow gives infinity and inexact
  p_overflow_inf_r9: assert property (@(posedge clk) disable iff (rst)
    (outValid && flags[2]) |-> (flags[0] && result[30:0] == 31'h7F800000));

  // R10: underflow gives zero and inexact
  p_underflow_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (outValid && flags[1]) |-> (flags[0] && result[30:0] == 31'h0));

  // R11: no subnormal pattern is ever produced
  p_no_subnormal_r11: assert property (@(posedge clk) disable iff (rst)
    outValid |-> !(result[30:23] == 8'h0 && result[22:0] != 23'h0));

  // R12: divide-by-zero never raised
  p_no_divzero_r12: assert property (@(posedge clk) disable iff (rst)
    outValid |-> !flags[3]);
endmodule

bind fp32_addsub fp32_addsub_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .outValid (outValid),
  .result   (result),
  .flags    (flags)
);

// File: tb/fp32_addsub_tb.sv
module fp32_addsub_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        subSel = 1'b0;
  logic        outValid;
  logic [31:0] result;
  logic [4:0]  flags;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  fp32_addsub u_dut (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .opA      (opA),
    .opB      (opB),
    .subSel   (subSel),
    .outValid (outValid),
    .result   (result),
    .flags    (flags)
  );

  // {opA, opB, subSel, result, flags, requirement}
  localparam int NV = 26;
  localparam logic [105:0] VEC [NV] = '{
    {32'h3F800000, 32'h3F800000, 1'b0, 32'h40000000, 5'h00, 4'd3},  // R3 1+1
    {32'h3FC00000, 32'h40100000, 1'b0, 32'h40700000, 5'h00, 4'd3},  // R3 1.5+2.25
    {32'hBF800000, 32'h3F000000, 1'b0, 32'hBF000000, 5'h00, 4'd3},  // R3 -1+0.5
    {32'h3F800000, 32'h40000000, 1'b1, 32'hBF800000, 5'h00, 4'd4},  // R4 1-2
    {32'h3F800000, 32'h3F7FFFFF, 1'b1, 32'h33800000, 5'h00, 4'd4},  // R4 deep cancellation
    {32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, 5'h01, 4'd3},  // R3 tie, stays even
    {32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002, 5'h01, 4'd3},  // R3 tie, up to even
    {32'h3F800000, 32'h33C00000, 1'b0, 32'h3F800001, 5'h01, 4'd3},  // R3 above half
    {32'h3F7FFFFF, 32'h33800000, 1'b0, 32'h3F800000, 5'h00, 4'd3},  // R3 add carry, exact
    {32'h3FFFFFFF, 32'h33800000, 1'b0, 32'h40000000, 5'h01, 4'd3},  // R3 round carry to exponent
    {32'h3F800000, 32'h3F800000, 1'b1, 32'h00000000, 5'h00, 4'd5},  // R5 x-x
    {32'h80000000, 32'h80000000, 1'b0, 32'h80000000, 5'h00, 4'd5},  // R5 -0 + -0
    {32'h00000000, 32'h80000000, 1'b0, 32'h00000000, 5'h00, 4'd5},  // R5 +0 + -0
    {32'h7F800000, 32'hFF800000, 1'b0, 32'h7FC00000, 5'h10, 4'd6},  // R6 inf + -inf
    {32'h7F800000, 32'h7F800000, 1'b1, 32'h7FC00000, 5'h10, 4'd6},  // R6 inf - inf
    {32'h7FA00000, 32'h3F800000, 1'b0, 32'h7FC00000, 5'h00, 4'd7},  // R7 NaN on a
    {32'h3F800000, 32'hFFC00001, 1'b1, 32'h7FC00000, 5'h00, 4'd7},  // R7 NaN on b
    {32'h7F800000, 32'h3F800000, 1'b0, 32'h7F800000, 5'h00, 4'd8},  // R8 inf + 1
    {32'h3F800000, 32'h7F800000, 1'b1, 32'hFF800000, 5'h00, 4'd8},  // R8 1 - inf
    {32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, 5'h05, 4'd9},  // R9 max + max
    {32'h7F7FFFFF, 32'h73000000, 1'b0, 32'h7F800000, 5'h05, 4'd9},  // R9 overflow by rounding
    {32'hFF7FFFFF, 32'hFF7FFFFF, 1'b0, 32'hFF800000, 5'h05, 4'd9},  // R9 negative overflow
    {32'h00C00000, 32'h00800000, 1'b1, 32'h00000000, 5'h03, 4'd10}, // R10 positive flush
    {32'h80C00000, 32'h80800000, 1'b1, 32'h80000000, 5'h03, 4'd10}, // R10 negative flush
    {32'h00000001, 32'h3F800000, 1'b0, 32'h3F800000, 5'h00, 4'd11}, // R11 subnormal as zero
    {32'h007FFFFF, 32'h807FFFFF, 1'b0, 32'h00000000, 5'h00, 4'd11}  // R11 two subnormals
  };

  task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [31:0] a, input logic [31:0] b, input logic s);
    inValid = v;
    opA     = a;
    opB     = b;
    subSel  = s;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R2: outputs held clear during reset
    chk(2, "valid in reset", {31'b0, outValid}, 32'h0);
    chk(2, "result in reset", result, 32'h0);
    chk(2, "flags in reset", {27'b0, flags}, 32'h0);
    rst = 1'b0;

    // R1 with the vector table: one operation per cycle, six-cycle latency
    for (int i = 0; i < NV + 6; i++) begin
      @(negedge clk);
      if (i >= 6) begin
        logic [105:0] v;
        v = VEC[i-6];
        chk(1, "valid in stream", {31'b0, outValid}, 32'h1);
        chk(int'(v[3:0]), "result", result, v[40:9]);
        chk(int'(v[3:0]), "flags", {27'b0, flags}, {27'b0, v[8:4]});
      end else begin
        chk(1, "valid before first result", {31'b0, outValid}, 32'h0);
      end
      if (i < NV) drive(1'b1, VEC[i][105:74], VEC[i][73:42], VEC[i][41]);
      else        drive(1'b0, 32'h0, 32'h0, 1'b0);
    end

    // R1: an isolated operation surfaces on exactly the sixth edge
    repeat (3) @(negedge clk);
    drive(1'b1, 32'h40400000, 32'h3F800000, 1'b0); // 3 + 1 = 4
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      chk(1, "isolated valid timing", {31'b0, outValid}, (k == 6) ? 32'h1 : 32'h0);
      if (k == 6) chk(1, "isolated result", result, 32'h40800000);
      drive(1'b0, 32'h7F800000, 32'hFF800000, 1'b0);
    end

    // R2: operations in flight are dropped by reset
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      drive(1'b1, 32'h3F800000, 32'h3F800000, 1'b0);
    end
    @(negedge clk);
    drive(1'b0, 32'h0, 32'h0, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(2, "valid after mid-flight reset", {31'b0, outValid}, 32'h0);
    end
    chk(2, "result after mid-flight reset", result, 32'h0);
    chk(2, "flags after mid-flight reset", {27'b0, flags}, 32'h0);

    // R12: divide-by-zero bit stays low across a flag-heavy case
    drive(1'b1, 32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0);
    @(negedge clk);
    drive(1'b0, 32'h0, 32'h0, 1'b0);
    repeat (5) @(negedge clk);
    chk(12, "divZero bit", {31'b0, flags[3]}, 32'h0);
    chk(9, "overflow repeat", {27'b0, flags}, 32'h05);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule